// File: doc/BRIEF.md
# Character String Move/Compare Engine

This block runs string operations on 6-bit characters stored ten per 60-bit word in a word-addressed memory. Each operand is named by an 18-bit word address and a character slot from 1 to 10, so a string may begin anywhere inside a word and run across any number of words. One command either copies a string from a source position to a destination position, or compares two strings character by character. A compare reports less, equal or greater, together with the index of the first character that differs. A collated compare first maps each character through a loadable 64-entry ordering table.

The block works one character per step. It keeps one cached source word and one cached destination word. A destination word that the string covers only in part is read, patched and written back, so characters outside the string keep their values. Memory traffic goes through a single request channel with a valid/ready handshake. Once the engine raises `mem_req_valid`, it holds the address, the write flag and the write data steady until the memory accepts the request by raising `mem_req_ready`. The memory can therefore apply back-pressure for any number of cycles. Each accepted read is answered later by a one-cycle `mem_rsp_valid`, and the engine issues no new request while a read is outstanding. Writes get no response.

Top module: `strmc_engine`

## Requirements
- R1: Character slot k of a word (k = 1..10) occupies bits [59-6(k-1) : 54-6(k-1)]. A move copies characters in order, and after slot 10 a cursor steps to slot 1 of the next word address.
- R2: Destination characters outside the moved string keep their previous values, including the other characters of partly covered words.
- R3: Operation code 2'b00 is a short move. Only the low 7 bits of `cmd_len` set its length (at most 127), and the upper length bits have no effect.
- R4: Operation code 2'b01 is a long move. All 12 bits of `cmd_len` set its length, up to 4095 characters.
- R5: Operation code 2'b10 is a compare of the source string against the destination string. It stops at the first unequal character. `cmp_result` is 2'b01 when the source character is smaller, 2'b10 when it is larger and 2'b00 when all characters match. `cmp_index` is the 1-based position of the mismatch, or 0 when the strings are equal. Moves report 2'b00 and 0.
- R6: Operation code 2'b11 is a collated compare. Both characters are replaced by their table entries before they are compared. A table entry is written by `tbl_we` with `tbl_idx` and `tbl_val`. After reset, every entry equals its own index. A plain compare ignores the table.
- R7: A length of zero raises `done` in the cycle after the start. The result is 2'b00, the index is 0, and no memory request is made.
- R8: A compare or collated compare never issues a memory write.
- R9: `busy` is high from the cycle after an accepted start up to and including the single cycle in which `done` pulses. A `cmd_start` while `busy` is high is ignored.
- R10: A memory request keeps its valid, address, write flag and write data stable until it is accepted.
- R11: After reset, `busy`, `done` and `mem_req_valid` are low, and `cmp_result` and `cmp_index` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse, taken only while idle |
| cmd_op | input | 2 | Operation code |
| cmd_src_addr | input | 18 | Source word address |
| cmd_src_chr | input | 4 | Source starting slot, 1..10 |
| cmd_dst_addr | input | 18 | Destination (second operand) word address |
| cmd_dst_chr | input | 4 | Destination starting slot, 1..10 |
| cmd_len | input | 12 | Length in characters |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cmp_result | output | 2 | Compare outcome |
| cmp_index | output | 12 | 1-based mismatch index, 0 if equal |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 18 | Memory word address |
| mem_req_wdata | output | 60 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 60 | Read data |
| tbl_we | input | 1 | Ordering table write enable |
| tbl_idx | input | 6 | Ordering table entry |
| tbl_val | input | 6 | Value written to the entry |

## Verification
The bench builds the engine with the default parameters: 18-bit addresses, 12-bit lengths and a 7-bit short-move length. With these values a long move of 300 characters crosses about thirty words, and a short move given a length of 197 must shrink to 69. The memory model withholds ready on roughly one cycle in four, so requests are held under back-pressure in the middle of moves. Mismatches placed deep inside strings, together with a reversed ordering table, show that a collated compare reverses the outcome of a plain compare.

// File: rtl/strmc_pkg.sv
package strmc_pkg;
  localparam int CHR_W  = 6;
  localparam int CPW    = 10;
  localparam int WORD_W = CHR_W * CPW;
  localparam int POS_W  = $clog2(CPW + 1);

  typedef enum logic [1:0] {
    OP_SMOVE = 2'b00,
    OP_LMOVE = 2'b01,
    OP_CMP   = 2'b10,
    OP_CCMP  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RES_EQ = 2'b00,
    RES_LT = 2'b01,
    RES_GT = 2'b10
  } res_e;

  // Slot 1 sits at the top of the word, slot CPW at the bottom.
  function automatic logic [CHR_W-1:0] chr_get(logic [WORD_W-1:0] w, logic [POS_W-1:0] k);
    logic [WORD_W-1:0] sh;
    sh = w >> ((CPW - int'(k)) * CHR_W);
    return sh[CHR_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] chr_put(logic [WORD_W-1:0] w, logic [POS_W-1:0] k,
                                                logic [CHR_W-1:0] c);
    logic [WORD_W-1:0] m;
    logic [WORD_W-1:0] v;
    int sa;
    sa = (CPW - int'(k)) * CHR_W;
    m  = {{(WORD_W-CHR_W){1'b0}}, {CHR_W{1'b1}}} << sa;
    v  = {{(WORD_W-CHR_W){1'b0}}, c} << sa;
    return (w & ~m) | v;
  endfunction
endpackage

// File: rtl/strmc_cursor.sv
module strmc_cursor
  import strmc_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [POS_W-1:0]  ld_pos,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic [POS_W-1:0]  pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(CPW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      pos  <= POS_W'(1);
    end else if (load) begin
      addr <= ld_addr;
      pos  <= ld_pos;
    end else if (adv) begin
      if (pos == LAST) begin
        pos  <= POS_W'(1);
        addr <= addr + ADDR_W'(1);
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  // R1: stepping past the last slot lands on slot 1 of the next word
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && pos == LAST |=> pos == POS_W'(1) && addr == $past(addr) + ADDR_W'(1));

  // R1: inside a word the slot moves up by one and the word stays
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && pos != LAST |=> pos == $past(pos) + POS_W'(1) && $stable(addr));
endmodule

// File: rtl/strmc_collate.sv
module strmc_collate
  import strmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CHR_W-1:0] widx,
  input  logic [CHR_W-1:0] wval,
  input  logic [CHR_W-1:0] a_in,
  input  logic [CHR_W-1:0] b_in,
  output logic [CHR_W-1:0] a_out,
  output logic [CHR_W-1:0] b_out
);
  localparam int ENTRIES = 1 << CHR_W;

  logic [CHR_W-1:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CHR_W'(i);
    end else if (we) begin
      tbl[widx] <= wval;
    end
  end

  assign a_out = tbl[a_in];
  assign b_out = tbl[b_in];

  // R6: a loaded entry reads back the value written
  a_r6_tbl_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tbl[$past(widx)] == $past(wval));
endmodule

// File: rtl/strmc_engine.sv
module strmc_engine
  import strmc_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int LEN_W       = 12,
  parameter int SHORT_LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_src_addr,
  input  logic [POS_W-1:0]  cmd_src_chr,
  input  logic [ADDR_W-1:0] cmd_dst_addr,
  input  logic [POS_W-1:0]  cmd_dst_chr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cmp_result,
  output logic [LEN_W-1:0]  cmp_index,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  input  logic              tbl_we,
  input  logic [CHR_W-1:0]  tbl_idx,
  input  logic [CHR_W-1:0]  tbl_val
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_RSRC, S_WSRC, S_RDST, S_WDST, S_WB, S_STEP, S_FIN
  } state_e;

  state_e            state;
  op_e               op_q;
  logic [LEN_W-1:0]  rem_q, cnt_q, len_q, idx_q, eff_len;
  logic [1:0]        res_q;
  logic [WORD_W-1:0] sbuf, dbuf;
  logic [ADDR_W-1:0] sbuf_addr, dbuf_addr, s_addr, d_addr;
  logic [POS_W-1:0]  s_pos, d_pos;
  logic              sv, dv, dirty;
  logic              start_ok, step_adv, is_cmp, mismatch;
  logic [CHR_W-1:0]  sch, dch, col_a, col_b, ca, cb;

  always_comb begin
    if (cmd_op == OP_SMOVE) eff_len = LEN_W'(cmd_len[SHORT_LEN_W-1:0]);
    else                    eff_len = cmd_len;
  end

  assign start_ok = (state == S_IDLE) && cmd_start;
  assign is_cmp   = op_q[1];
  assign sch      = chr_get(sbuf, s_pos);
  assign dch      = chr_get(dbuf, d_pos);
  assign ca       = (op_q == OP_CCMP) ? col_a : sch;
  assign cb       = (op_q == OP_CCMP) ? col_b : dch;
  assign mismatch = is_cmp && (ca != cb);
  assign step_adv = (state == S_STEP) && !mismatch;

  strmc_cursor #(.ADDR_W(ADDR_W)) u_src_cur (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .ld_addr(cmd_src_addr),
    .ld_pos(cmd_src_chr), .adv(step_adv), .addr(s_addr), .pos(s_pos));

  strmc_cursor #(.ADDR_W(ADDR_W)) u_dst_cur (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .ld_addr(cmd_dst_addr),
    .ld_pos(cmd_dst_chr), .adv(step_adv), .addr(d_addr), .pos(d_pos));

  strmc_collate u_col (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wval(tbl_val),
    .a_in(sch), .b_in(dch), .a_out(col_a), .b_out(col_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= OP_SMOVE;
      rem_q     <= '0;
      cnt_q     <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      res_q     <= RES_EQ;
      sbuf      <= '0;
      dbuf      <= '0;
      sbuf_addr <= '0;
      dbuf_addr <= '0;
      sv        <= 1'b0;
      dv        <= 1'b0;
      dirty     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmd_start) begin
          op_q  <= op_e'(cmd_op);
          rem_q <= eff_len;
          len_q <= eff_len;
          cnt_q <= '0;
          idx_q <= '0;
          res_q <= RES_EQ;
          sv    <= 1'b0;
          dv    <= 1'b0;
          dirty <= 1'b0;
          state <= (eff_len == '0) ? S_FIN : S_CHECK;
        end
        S_CHECK: begin
          if (rem_q == '0)                        state <= dirty ? S_WB : S_FIN;
          else if (!sv || sbuf_addr != s_addr)    state <= S_RSRC;
          else if (!dv || dbuf_addr != d_addr)    state <= dirty ? S_WB : S_RDST;
          else                                    state <= S_STEP;
        end
        S_RSRC: if (mem_req_ready) state <= S_WSRC;
        S_WSRC: if (mem_rsp_valid) begin
          sbuf      <= mem_rsp_rdata;
          sbuf_addr <= s_addr;
          sv        <= 1'b1;
          state     <= S_CHECK;
        end
        S_RDST: if (mem_req_ready) state <= S_WDST;
        S_WDST: if (mem_rsp_valid) begin
          dbuf      <= mem_rsp_rdata;
          dbuf_addr <= d_addr;
          dv        <= 1'b1;
          state     <= S_CHECK;
        end
        S_WB: if (mem_req_ready) begin
          dirty <= 1'b0;
          state <= S_CHECK;
        end
        S_STEP: begin
          if (mismatch) begin
            res_q <= (ca < cb) ? RES_LT : RES_GT;
            idx_q <= cnt_q + LEN_W'(1);
            state <= S_FIN;
          end else begin
            if (!is_cmp) begin
              dbuf  <= chr_put(dbuf, d_pos, sch);
              dirty <= 1'b1;
            end
            rem_q <= rem_q - LEN_W'(1);
            cnt_q <= cnt_q + LEN_W'(1);
            state <= S_CHECK;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign done          = (state == S_FIN);
  assign cmp_result    = res_q;
  assign cmp_index     = idx_q;
  assign mem_req_valid = (state == S_RSRC) || (state == S_RDST) || (state == S_WB);
  assign mem_req_write = (state == S_WB);
  assign mem_req_addr  = (state == S_RSRC) ? s_addr : ((state == S_WB) ? dbuf_addr : d_addr);
  assign mem_req_wdata = dbuf;

  // R10: a request waiting for ready holds all of its fields
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R9: done lasts one cycle and busy falls with it
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R8: compares only read
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && is_cmp |-> !mem_req_write);

  // R5: an equal outcome carries index 0
  a_r5_eq_index: assert property (@(posedge clk) disable iff (!rst_n)
    done && cmp_result == RES_EQ |-> cmp_index == '0);

  // R5: a mismatch index lies inside the string
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done && cmp_result != RES_EQ |-> cmp_index != '0 && cmp_index <= len_q);

  // R7: a zero length finishes in the next cycle
  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && eff_len == '0 |=> done);
endmodule

// File: tb/strmc_engine_tb.sv
`timescale 1ns/1ps
module strmc_engine_tb_top;
  import strmc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [17:0] cmd_src_addr = '0, cmd_dst_addr = '0;
  logic [3:0]  cmd_src_chr = 4'd1, cmd_dst_chr = 4'd1;
  logic [11:0] cmd_len = '0;
  logic        busy, done;
  logic [1:0]  cmp_result;
  logic [11:0] cmp_index;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready, mem_rsp_valid;
  logic [17:0] mem_req_addr;
  logic [59:0] mem_req_wdata, mem_rsp_rdata;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_idx = '0, tbl_val = '0;

  always #2.5 clk = ~clk;

  strmc_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_src_addr(cmd_src_addr), .cmd_src_chr(cmd_src_chr),
    .cmd_dst_addr(cmd_dst_addr), .cmd_dst_chr(cmd_dst_chr), .cmd_len(cmd_len),
    .busy(busy), .done(done), .cmp_result(cmp_result), .cmp_index(cmp_index),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_val(tbl_val));

  int vectors = 0, miscompares = 0;
  int req_cnt = 0, wr_cnt = 0;
  logic [59:0] dmem [int];
  logic [59:0] rmem [int];
  logic [5:0]  ctab [64];
  logic [15:0] lf = 16'hACE1;

  typedef struct { logic [1:0] res; logic [11:0] idx; string tag; } exp_t;
  exp_t sbq[$];

  function automatic logic [59:0] dm_rd(int a);
    return dmem.exists(a) ? dmem[a] : 60'd0;
  endfunction
  function automatic logic [59:0] rm_rd(int a);
    return rmem.exists(a) ? rmem[a] : 60'd0;
  endfunction
  function automatic logic [5:0] rg(logic [59:0] w, int k);
    return w[59-6*(k-1) -: 6];
  endfunction
  function automatic logic [59:0] rp(logic [59:0] w, int k, logic [5:0] c);
    logic [59:0] t;
    t = w;
    t[59-6*(k-1) -: 6] = c;
    return t;
  endfunction

  // memory model: random back-pressure, read data one cycle after acceptance
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
    end else begin
      lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        req_cnt++;
        if (mem_req_write) begin
          dmem[int'(mem_req_addr)] = mem_req_wdata;
          wr_cnt++;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= dm_rd(int'(mem_req_addr));
        end
      end
      mem_req_ready <= lf[0] | lf[3];
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pop one expected outcome for every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(cmp_result == e.res, e.tag, "cmp_result", cmp_result, e.res);
        chk(cmp_index == e.idx, e.tag, "cmp_index", cmp_index, e.idx);
      end
    end
  end

  task automatic fill(int lo, int hi, int seed);
    for (int a = lo; a <= hi; a++) begin
      logic [63:0] w;
      w = 64'(a) * 64'h9E3779B97F4A7C15 ^ (64'(seed) << 20);
      dmem[a] = w[59:0];
      rmem[a] = w[59:0];
    end
  endtask

  task automatic locate(int base, int k0, int n, output int a, output int k);
    int off;
    off = (k0 - 1) + (n - 1);
    a = base + off / 10;
    k = off % 10 + 1;
  endtask

  task automatic poke(int a, int k, logic [5:0] c);
    dmem[a] = rp(dm_rd(a), k, c);
    rmem[a] = rp(rm_rd(a), k, c);
  endtask

  // driver half: predict the outcome with the reference model and queue it
  task automatic predict(logic [1:0] op, int sa, int sc, int da, int dc, int len, string tag);
    exp_t e;
    int n;
    e.res = 2'b00; e.idx = '0; e.tag = tag;
    n = (op == 2'b00) ? (len & 127) : (len & 4095);
    for (int i = 0; i < n; i++) begin
      logic [5:0] a, b;
      a = rg(rm_rd(sa), sc);
      b = rg(rm_rd(da), dc);
      if (op[1] == 1'b0) begin
        rmem[da] = rp(rm_rd(da), dc, a);
      end else begin
        if (op == 2'b11) begin a = ctab[a]; b = ctab[b]; end
        if (a != b) begin
          e.res = (a < b) ? 2'b01 : 2'b10;
          e.idx = 12'(i + 1);
          break;
        end
      end
      if (sc == 10) begin sc = 1; sa++; end else sc++;
      if (dc == 10) begin dc = 1; da++; end else dc++;
    end
    sbq.push_back(e);
  endtask

  task automatic pulse(logic [1:0] op, int sa, int sc, int da, int dc, int len);
    @(negedge clk);
    cmd_start = 1'b1; cmd_op = op;
    cmd_src_addr = 18'(sa); cmd_src_chr = 4'(sc);
    cmd_dst_addr = 18'(da); cmd_dst_chr = 4'(dc);
    cmd_len = 12'(len);
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(logic [1:0] op, int sa, int sc, int da, int dc, int len, string tag);
    predict(op, sa, sc, da, dc, len, tag);
    pulse(op, sa, sc, da, dc, len);
    wait_done();
  endtask

  task automatic chk_mem(int lo, int hi, string tag);
    int bad;
    bad = 0;
    for (int a = lo; a <= hi; a++) begin
      if (dm_rd(a) !== rm_rd(a)) begin
        if (bad == 0) $display("FAIL %s memory word %0d actual=%0h expected=%0h",
                               tag, a, dm_rd(a), rm_rd(a));
        bad++;
      end
    end
    vectors++;
    if (bad != 0) miscompares++;
  endtask

  task automatic load_tbl(int i, int v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 6'(i); tbl_val = 6'(v);
    @(negedge clk);
    tbl_we = 1'b0;
    ctab[i] = 6'(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int a, k, r0, w0;
    for (int i = 0; i < 64; i++) ctab[i] = 6'(i);
    repeat (5) @(negedge clk);
    // R11: reset state
    chk(busy == 1'b0 && done == 1'b0, "R11", "busy/done in reset", {busy, done}, 0);
    chk(mem_req_valid == 1'b0, "R11", "mem_req_valid in reset", mem_req_valid, 0);
    chk(cmp_result == 2'b00 && cmp_index == '0, "R11", "result in reset",
        {cmp_result, cmp_index}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    fill(995, 1015, 1); fill(1995, 2015, 2);
    // R1 R2: 72 characters from word 1000 slot 3 to word 2000 slot 9
    run_cmd(2'b00, 1000, 3, 2000, 9, 72, "R1");
    chk_mem(1995, 2015, "R1 R2");

    // R5 R8: equal strings
    w0 = wr_cnt;
    run_cmd(2'b10, 1000, 3, 2000, 9, 72, "R5");
    chk(wr_cnt == w0, "R8", "writes during compare", wr_cnt - w0, 0);

    // R5: mismatch at index 40, source smaller
    locate(1000, 3, 40, a, k); poke(a, k, 6'd0);
    locate(2000, 9, 40, a, k); poke(a, k, 6'd63);
    run_cmd(2'b10, 1000, 3, 2000, 9, 72, "R5");
    // R5: operands swapped, source larger
    run_cmd(2'b10, 2000, 9, 1000, 3, 72, "R5");

    // R6: identity table after reset, then a reversed table flips the order
    run_cmd(2'b11, 1000, 3, 2000, 9, 72, "R6");
    for (int i = 0; i < 64; i++) load_tbl(i, 63 - i);
    w0 = wr_cnt;
    run_cmd(2'b11, 1000, 3, 2000, 9, 72, "R6");
    chk(wr_cnt == w0, "R8", "writes during collated compare", wr_cnt - w0, 0);
    run_cmd(2'b10, 1000, 3, 2000, 9, 72, "R6");

    // R3: length 197 truncates to 69
    fill(1100, 1130, 3); fill(2095, 2130, 4);
    run_cmd(2'b00, 1100, 5, 2100, 2, 12'h0C5, "R3");
    chk_mem(2095, 2130, "R3");

    // R4 R10: long move of 300 characters under back-pressure
    fill(1200, 1240, 5); fill(2195, 2240, 6);
    run_cmd(2'b01, 1200, 7, 2200, 4, 300, "R4");
    chk_mem(2195, 2240, "R4 R10");

    // R2: both ends of the destination only partly covered
    fill(1300, 1310, 7); fill(2298, 2310, 8);
    run_cmd(2'b01, 1300, 6, 2300, 3, 25, "R2");
    chk_mem(2298, 2310, "R2");

    // R7: zero length makes no requests and finishes at once
    r0 = req_cnt;
    predict(2'b01, 1300, 1, 2300, 1, 0, "R7");
    pulse(2'b01, 1300, 1, 2300, 1, 0);
    chk(done == 1'b1, "R7", "done after zero-length start", done, 1);
    wait_done();
    chk(req_cnt == r0, "R7", "requests for zero length", req_cnt - r0, 0);
    chk_mem(2298, 2310, "R7");

    // R9: busy while running, a second start is ignored
    fill(1400, 1410, 9); fill(2398, 2410, 10);
    predict(2'b01, 1400, 2, 2400, 5, 50, "R9");
    pulse(2'b01, 1400, 2, 2400, 5, 50);
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    repeat (3) @(negedge clk);
    pulse(2'b00, 1400, 1, 2405, 1, 9);
    wait_done();
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after done", busy, 0);
    chk(sbq.size() == 0, "R9", "outstanding expected results", sbq.size(), 0);
    chk_mem(2398, 2410, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule